// File: doc/BRIEF.md
# Host Controller Interrupt Status and Response Unit

This unit keeps the event status word, the per-source mask and the command response buffer of a card host controller. Command and data logic raise status bits through a set vector. The CPU clears them by writing zeros over a 16-bit register port. The unit sends the CPU a single-cycle interrupt pulse only when the set of unmasked pending events goes from empty to non-empty. That can happen because an event arrives, or because a mask write uncovers an event that was already latched but masked.

The response buffer holds four 32-bit words. Each word pushed in by the command logic enters slot 0, and the older words move up one slot. The oldest word drops off the top. A push marked as the last word of a response sets the response-end status bit. When the status register is read, the card-presence flags come from a live input.

Top module: `sdh_irq_resp`

## Requirements
- R1: After reset the status reads zero apart from the card flags, the response buffer reads zero, irq_pulse is low, and the mask reads 0x031D (address 2) and 0x8B7F (address 3), so every source starts masked.
- R2: Only status and mask bits in the pattern 0x8B7F031D exist. A set or write to any other bit is ignored and reads back as 0.
- R3: A write to status low (address 0) or status high (address 1) clears each bit written as 0 and keeps each bit written as 1.
- R4: irq_pulse is high for exactly one cycle, in the cycle after the edge where (status AND NOT mask) turns from zero to non-zero. There is no pulse while another unmasked event is already pending, and none for a masked event.
- R5: A mask write (address 2 or 3) that uncovers an already pending status bit produces the R4 pulse.
- R6: Each response push shifts the older words up by one slot and stores the new word in slot 0. Slot k is read at addresses 4+2k (bits 15:0) and 5+2k (bits 31:16).
- R7: A response push with rsp_last high sets status bit 0. A push without rsp_last leaves bit 0 unchanged.
- R8: A read of status low returns bits 4 and 5 set when card_present is 1, and bit 3 set when it is 0.
- R9: A write to mask high sets status bit 24 when fifo_empty is 0, or status bit 25 when fifo_empty is 1.
- R10: soft_rst clears the status and the response buffer and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of status and responses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index: 0/1 status lo/hi, 2/3 mask lo/hi, 4..11 response halfwords |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| evt_set | input | 32 | One-cycle status set requests |
| rsp_push | input | 1 | Push a response word |
| rsp_word | input | 32 | Response word |
| rsp_last | input | 1 | Pushed word ends the response |
| card_present | input | 1 | Card detected |
| fifo_empty | input | 1 | Selected data FIFO is empty |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The hardest case to reach from the ports is an interrupt that comes from a mask write rather than from an event. To reach it, the stimulus first latches an event while its source is masked and confirms that no pulse appears. It then unmasks the source and expects the pulse one cycle after the write. The upper-mask write is harder still, because it also raises bit 24 in the same cycle. The bench therefore holds fifo_empty low, unmasks bit 24, and checks for exactly one pulse. The stimulus also covers the reverse case, where an unmasked event arrives while another is already pending and no pulse may appear.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
    localparam int          STAT_W     = 32;
    localparam logic [31:0] IMPL_BITS  = 32'h8B7F_031D;
    localparam int          BIT_RSPEND = 0;
    localparam int          BIT_RXRDY  = 24;
    localparam int          BIT_TXREQ  = 25;
    localparam logic [15:0] CARD_IN_RD  = 16'h0030;
    localparam logic [15:0] CARD_OUT_RD = 16'h0008;
    localparam int REG_STAT_LO = 0;
    localparam int REG_STAT_HI = 1;
    localparam int REG_MASK_LO = 2;
    localparam int REG_MASK_HI = 3;
    localparam int REG_RSP0    = 4;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
        logic              irq;
    } stat_state_t;
endpackage

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [1:0]        wr_stat,
    input  logic [1:0]        wr_mask,
    input  logic [REG_W-1:0]  wdata,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              rsp_end,
    input  logic              fifo_empty,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq_q
);
    localparam int HALVES = STAT_W / REG_W;

    stat_state_t st_d, st_q;
    logic [STAT_W-1:0] set_d;
    logic [STAT_W-1:0] pend_q;

    assign pend_q = st_q.status & ~st_q.mask;

    always_comb begin
        st_d  = st_q;
        set_d = evt_set;
        for (int h = 0; h < HALVES; h++) begin
            if (wr_stat[h]) st_d.status[h*REG_W +: REG_W] = st_q.status[h*REG_W +: REG_W] & wdata;
            if (wr_mask[h]) st_d.mask[h*REG_W +: REG_W]   = wdata & IMPL_BITS[h*REG_W +: REG_W];
        end
        if (rsp_end) set_d[BIT_RSPEND] = 1'b1;
        if (wr_mask[HALVES-1]) begin
            if (fifo_empty) set_d[BIT_TXREQ] = 1'b1;
            else            set_d[BIT_RXRDY] = 1'b1;
        end
        st_d.status = (st_d.status | set_d) & IMPL_BITS;
        if (soft_rst) st_d.status = '0;
        st_d.irq = (pend_q == '0) && ((st_d.status & ~st_d.mask) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= IMPL_BITS;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;
    assign mask_q   = st_q.mask;
    assign irq_q    = st_q.irq;

    AST_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (pend_q != '0) && ($past(pend_q) == '0)); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R4
    AST_RSP_END_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rsp_end) && !$past(soft_rst) |-> status_q[BIT_RSPEND]); // R7
    AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stat[0]) && !$past(rsp_end) && !$past(soft_rst) |->
        (status_q[REG_W-1:0] & ~$past(wdata) & ~$past(evt_set[REG_W-1:0])) == '0); // R3
    AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) && ($past(wr_mask) == 2'b00) |-> mask_q == $past(mask_q)); // R10
endmodule

// File: rtl/sdh_rsp_buf.sv
module sdh_rsp_buf #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     push,
    input  logic [WORD_W-1:0]        word,
    output logic [DEPTH*WORD_W-1:0]  flat_q
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] slot;
    } rsp_state_t;

    rsp_state_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (push) begin
            for (int s = DEPTH-1; s > 0; s--) rb_d.slot[s] = rb_q.slot[s-1];
            rb_d.slot[0] = word;
        end
        if (soft_rst) rb_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat_q[g*WORD_W +: WORD_W] = rb_q.slot[g];
    end

    AST_RSP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(push) && !$past(soft_rst) |-> flat_q[WORD_W-1:0] == $past(word)); // R6
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(push) && !$past(soft_rst) |-> $stable(flat_q)); // R6
endmodule

// File: rtl/sdh_irq_resp.sv
module sdh_irq_resp
    import sdh_irq_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int RSP_WORDS = 4,
    parameter int ADDR_W    = $clog2(REG_RSP0 + RSP_WORDS*STAT_W/REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              rsp_push,
    input  logic [STAT_W-1:0] rsp_word,
    input  logic              rsp_last,
    input  logic              card_present,
    input  logic              fifo_empty,
    output logic              irq_pulse
);
    localparam int RSP_HW    = RSP_WORDS * STAT_W / REG_W;
    localparam int RSP_SEL_W = $clog2(RSP_HW);

    logic [1:0]                  wr_stat, wr_mask;
    logic [STAT_W-1:0]           status_q, mask_q;
    logic [RSP_WORDS*STAT_W-1:0] rsp_flat;
    logic [REG_W-1:0]            rsp_hw [RSP_HW];
    logic [RSP_SEL_W-1:0]        rsp_sel;

    assign wr_stat = {reg_wr && (int'(reg_addr) == REG_STAT_HI), reg_wr && (int'(reg_addr) == REG_STAT_LO)};
    assign wr_mask = {reg_wr && (int'(reg_addr) == REG_MASK_HI), reg_wr && (int'(reg_addr) == REG_MASK_LO)};

    sdh_irq_status #(.REG_W(REG_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wr_stat    (wr_stat),
        .wr_mask    (wr_mask),
        .wdata      (reg_wdata),
        .evt_set    (evt_set),
        .rsp_end    (rsp_push && rsp_last),
        .fifo_empty (fifo_empty),
        .status_q   (status_q),
        .mask_q     (mask_q),
        .irq_q      (irq_pulse)
    );

    sdh_rsp_buf #(.WORD_W(STAT_W), .DEPTH(RSP_WORDS)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .push     (rsp_push),
        .word     (rsp_word),
        .flat_q   (rsp_flat)
    );

    for (genvar g = 0; g < RSP_HW; g++) begin : g_hw
        assign rsp_hw[g] = rsp_flat[g*REG_W +: REG_W];
    end

    assign rsp_sel = RSP_SEL_W'(reg_addr - ADDR_W'(REG_RSP0));

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            REG_STAT_LO: reg_rdata = status_q[REG_W-1:0] | (card_present ? CARD_IN_RD : CARD_OUT_RD);
            REG_STAT_HI: reg_rdata = status_q[STAT_W-1:REG_W];
            REG_MASK_LO: reg_rdata = mask_q[REG_W-1:0];
            REG_MASK_HI: reg_rdata = mask_q[STAT_W-1:REG_W];
            default: begin
                if (int'(reg_addr) >= REG_RSP0 && int'(reg_addr) < REG_RSP0 + RSP_HW)
                    reg_rdata = rsp_hw[rsp_sel];
            end
        endcase
    end

    AST_CARD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) == REG_STAT_LO) |-> (card_present ? (reg_rdata[5:4] == 2'b11) : reg_rdata[3])); // R8
endmodule

// File: tb/sim_sdh_irq_resp.sv
module sim_sdh_irq_resp;
    localparam int IRQ_PROBE = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] evt_set = '0;
    logic        rsp_push = 1'b0;
    logic [31:0] rsp_word = '0;
    logic        rsp_last = 1'b0;
    logic        card_present = 1'b0;
    logic        fifo_empty = 1'b0;
    logic        irq_pulse;

    typedef struct {
        int          addr;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdh_irq_resp u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_set(evt_set), .rsp_push(rsp_push), .rsp_word(rsp_word),
        .rsp_last(rsp_last), .card_present(card_present),
        .fifo_empty(fifo_empty), .irq_pulse(irq_pulse)
    );

    // monitor: compares one queued expectation per cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                act = (it.addr == IRQ_PROBE) ? {15'd0, irq_pulse} : reg_rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic chk(input int addr, input logic [15:0] exp, input string tag);
        if (addr != IRQ_PROBE) reg_addr = 4'(addr);
        sb.push_back('{addr, exp, tag});
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = 4'(addr); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic evt(input logic [31:0] b);
        evt_set = b;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic push(input logic [31:0] w, input logic last);
        rsp_push = 1'b1; rsp_word = w; rsp_last = last;
        @(negedge clk);
        rsp_push = 1'b0; rsp_last = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(0, 16'h0008, "R1 status lo");
        chk(1, 16'h0000, "R1 status hi");
        chk(2, 16'h031D, "R1 mask lo");
        chk(3, 16'h8B7F, "R1 mask hi");
        chk(4, 16'h0000, "R1 rsp hw0");
        chk(IRQ_PROBE, 16'h0, "R1 irq low");
        // R8 card flags
        card_present = 1'b1;
        chk(0, 16'h0030, "R8 card present");
        // R2 only implemented bits, masked events give no pulse
        evt(32'hFFFF_FFFF);
        chk(IRQ_PROBE, 16'h0, "R4 masked no pulse");
        chk(0, 16'h033D, "R2 status lo");
        chk(1, 16'h8B7F, "R2 status hi");
        wr(0, 16'h0000); wr(1, 16'h0000);
        chk(0, 16'h0030, "R2 cleared lo");
        chk(1, 16'h0000, "R2 cleared hi");
        wr(2, 16'hFFFF);
        chk(2, 16'h031D, "R2 mask lo bits");
        // R3 write-zero-to-clear
        card_present = 1'b0;
        evt(32'h0300_0014);
        wr(1, 16'hFEFF);
        chk(1, 16'h0200, "R3 hi clear bit24 keep bit25");
        wr(0, 16'hFFFB);
        chk(0, 16'h0018, "R3 lo clear bit2 keep bit4");
        wr(0, 16'h0000); wr(1, 16'h0000);
        // R4 edge-only interrupt
        wr(2, 16'h0319);
        evt(32'h0000_0004);
        chk(IRQ_PROBE, 16'h1, "R4 pulse on event");
        chk(IRQ_PROBE, 16'h0, "R4 pulse one cycle");
        wr(2, 16'h0318);
        chk(IRQ_PROBE, 16'h0, "R4 no pulse while pending");
        evt(32'h0000_0001);
        chk(IRQ_PROBE, 16'h0, "R4 second event no pulse");
        wr(0, 16'h0000);
        evt(32'h0000_0001);
        chk(IRQ_PROBE, 16'h1, "R4 pulse after clear");
        wr(0, 16'h0000);
        wr(2, 16'h031D);
        // R5 mask write exposes pending event
        evt(32'h0000_0100);
        chk(IRQ_PROBE, 16'h0, "R5 masked pending");
        wr(2, 16'h021D);
        chk(IRQ_PROBE, 16'h1, "R5 pulse on unmask");
        chk(IRQ_PROBE, 16'h0, "R5 single pulse");
        wr(2, 16'h031D);
        wr(0, 16'h0000);
        // R9 upper mask write side effects
        fifo_empty = 1'b1;
        wr(3, 16'h8B7F);
        chk(1, 16'h0200, "R9 empty sets bit25");
        fifo_empty = 1'b0;
        wr(3, 16'h8B7F);
        chk(1, 16'h0300, "R9 nonempty sets bit24");
        wr(1, 16'h0000);
        wr(3, 16'h8A7F);
        chk(IRQ_PROBE, 16'h1, "R9 R5 unmask bit24 pulse");
        wr(3, 16'h8B7F);
        wr(1, 16'h0000);
        chk(1, 16'h0000, "R9 cleared");
        // R6 response shifting
        push(32'h1111_2222, 1'b0);
        chk(0, 16'h0008, "R7 no last keeps bit0");
        push(32'h3333_4444, 1'b0);
        chk(4, 16'h4444, "R6 slot0 lo");
        chk(5, 16'h3333, "R6 slot0 hi");
        chk(6, 16'h2222, "R6 slot1 lo");
        chk(7, 16'h1111, "R6 slot1 hi");
        chk(8, 16'h0000, "R6 slot2 empty");
        wr(2, 16'h031C);
        push(32'h5555_6666, 1'b0);
        push(32'h7777_8888, 1'b0);
        push(32'h9999_AAAA, 1'b1);
        chk(IRQ_PROBE, 16'h1, "R7 last push pulse");
        chk(0, 16'h0009, "R7 last sets bit0");
        chk(4, 16'hAAAA, "R6 newest in slot0");
        chk(10, 16'h4444, "R6 slot3 lo");
        chk(11, 16'h3333, "R6 slot3 hi oldest dropped");
        // R10 soft reset
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(0, 16'h0008, "R10 status cleared");
        chk(4, 16'h0000, "R10 rsp cleared");
        chk(11, 16'h0000, "R10 rsp top cleared");
        chk(2, 16'h031C, "R10 mask kept");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule